// File: doc/BRIEF.md
# Run-Mode Clock Source Controller

This block decides which of three oscillators clocks the core and the peripherals: the primary oscillator, the secondary external oscillator, or the internal oscillator block. Software writes a 2-bit run-mode select. The controller follows that select through a short, safe changeover. It also drives the enable lines of the oscillators and keeps three status flags: primary start-up complete, secondary running, and internal high-frequency stable.

A return to the primary oscillator happens in the background. The previous source keeps clocking while a start-up counter runs, followed by an optional PLL lock wait. Only after that does the changeover start. A request for the secondary oscillator waits until software has enabled that oscillator and it reports ready. The internal block has two oscillators: a low-frequency one and a high-frequency one. Which one is used depends on a 3-bit frequency field and a source bit. The controller reports the stability flag that belongs to the chosen oscillator.

Oscillators are modelled as ready/stable handshakes. The changeover is a registered source code on `act_src_o`, and that code changes after a short delay.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset release: `act_src_o`=0, `pri_en_o`=1, `ost_done_o`=0 and `sec_run_o`=0. `ost_done_o` rises on rising edge OST_CYCLES+1 after release.
- R2: Select decoding: `sel_i`=00 selects primary (code 0), 01 selects secondary (code 1), and any value with `sel_i[1]`=1 selects internal (code 2). While `sel_i[1]`=1, a change of `sel_i[0]` causes no switch.
- R3: A secondary request stays pending, with the current source still active, until `sec_en_i` and `sec_rdy_i` are both 1.
- R4: A switch completes on the SW_DLY-th rising edge at which the new target is ready, counted after the edge that latches the target. When the target is already ready, `act_src_o` changes on edge SW_DLY+1 after the select change.
- R5: On the edge that enters secondary run, `sec_run_o` becomes 1, `ost_done_o` becomes 0 and `pri_en_o` drops to 0.
- R6: On the edge that enters internal run, `ost_done_o` becomes 0 and `pri_en_o` drops to 0.
- R7: On a request to return to primary, `pri_en_o` rises at once and `act_src_o` keeps the old source. Without PLL, the switch completes on edge OST_CYCLES+SW_DLY after the select change.
- R8: With `pll_en_i`=1, the primary wait grows to OST_CYCLES+PLL_LOCK_CYCLES, so the switch completes on edge OST_CYCLES+PLL_LOCK_CYCLES+SW_DLY.
- R9: On the edge that completes a switch to primary, `ost_done_o` becomes 1, `sec_run_o` becomes 0 and `hf_stab_o` becomes 0.
- R10: `freq_i`=000 with `int_src_i`=0 selects the low-frequency internal oscillator. In that case `int_stab_o` follows `lf_rdy_i` and `lf_en_o` is 1 while internal run is targeted or active. Any other combination selects the high-frequency oscillator. In that case `int_stab_o` follows `hf_stab_o` and `hf_en_o` is 1 while internal run is targeted or active.
- R11: `hf_stab_o` rises HF_STAB_CYCLES edges after `hf_en_o` rises. It stays 1 when `freq_i` or `int_src_i` changes between two high-frequency selections.
- R12: `lf_en_o` is 1 whenever `wdt_en_i` or `fscm_en_i` is 1, including after internal run is left.
- R13: A select change made while a switch is pending restarts the delay toward the newest target. The superseded target never becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, one period per oscillator period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Run-mode select |
| sec_en_i | input | 1 | Secondary oscillator enabled by software |
| sec_rdy_i | input | 1 | Secondary oscillator ready |
| pll_en_i | input | 1 | Primary path uses the PLL |
| freq_i | input | 3 | Internal frequency field |
| int_src_i | input | 1 | Internal source bit, forces high-frequency source |
| lf_rdy_i | input | 1 | Low-frequency internal oscillator stable |
| wdt_en_i | input | 1 | Watchdog enabled, keeps the low-frequency oscillator on |
| fscm_en_i | input | 1 | Fail-safe clock monitor enabled, keeps the low-frequency oscillator on |
| act_src_o | output | 2 | Active source: 0 primary, 1 secondary, 2 internal |
| pri_en_o | output | 1 | Primary oscillator enable |
| ost_done_o | output | 1 | Primary start-up complete flag |
| sec_run_o | output | 1 | Secondary running flag |
| hf_en_o | output | 1 | High-frequency internal output enable |
| hf_stab_o | output | 1 | High-frequency internal stable flag |
| lf_en_o | output | 1 | Low-frequency internal oscillator enable |
| int_stab_o | output | 1 | Stability flag of the selected internal oscillator |

## Verification
Each result is due at a fixed edge, counted from the negative edge where the stimulus is driven:
- Enables and the internal stability selection are combinational, so they are checked after the very next edge.
- Source changes are due SW_DLY+1 edges after a select change when the target is ready, or SW_DLY edges after a late ready.
- Returns to primary are due OST_CYCLES(+PLL_LOCK_CYCLES)+SW_DLY edges after the request.
- `hf_stab_o` is due HF_STAB_CYCLES edges after enabling.

The scoreboard stores the absolute due edge with every expected item. It checks the edge just before each change as well as the edge of the change. It samples 1 ns after the rising edge, when all registers have settled.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  function automatic src_e sel_to_src(logic [1:0] sel);
    if (sel[1]) return SRC_INT;
    if (sel[0]) return SRC_SEC;
    return SRC_PRI;
  endfunction
endpackage

// File: rtl/ost_timer.sv
module ost_timer #(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pll_en_i,
  output logic rdy_o
);
  localparam int TotMax = OST_CYCLES + PLL_LOCK_CYCLES;
  localparam int CntW   = $clog2(TotMax + 1);

  logic [CntW-1:0] cnt_q, lim;

  assign lim = pll_en_i ? CntW'(TotMax) : CntW'(OST_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q < lim)   cnt_q <= cnt_q + CntW'(1);
  end

  assign rdy_o = en_i && (cnt_q >= lim);

  // a fresh start never reports ready at once
  assert_fresh_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !rdy_o);
endmodule

// File: rtl/switch_seq.sv
module switch_seq import clk_src_pkg::*; #(
  parameter int SW_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e tgt_i,
  input  logic pri_rdy_i,
  input  logic sec_ok_i,
  output src_e act_o,
  output src_e act_d_o
);
  localparam int CntW = $clog2(SW_DLY + 1);

  src_e            act_q, tgt_q, tgt_d;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic            tgt_rdy;

  always_comb begin
    case (tgt_i)
      SRC_PRI: tgt_rdy = pri_rdy_i;
      SRC_SEC: tgt_rdy = sec_ok_i;
      default: tgt_rdy = 1'b1;
    endcase
  end

  always_comb begin
    act_d_o = act_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q;
    if (tgt_i != tgt_q) begin
      // new target: restart the changeover
      tgt_d = tgt_i;
      cnt_d = '0;
    end else if (tgt_i != act_q && tgt_rdy) begin
      if (cnt_q == CntW'(SW_DLY - 1)) begin
        act_d_o = tgt_i;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CntW'(1);
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= SRC_PRI;
      tgt_q <= SRC_PRI;
      cnt_q <= '0;
    end else begin
      act_q <= act_d_o;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  assign act_o = act_q;

  assert_act_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q inside {SRC_PRI, SRC_SEC, SRC_INT});

  assert_sec_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == SRC_SEC && $past(act_q) != SRC_SEC) |-> $past(sec_ok_i));

  assert_pri_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == SRC_PRI && $past(act_q) != SRC_PRI) |-> $past(pri_rdy_i));

  assert_retarget_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tgt_i) != $past(tgt_q)) |-> act_q == $past(act_q));
endmodule

// File: rtl/int_osc_mon.sv
module int_osc_mon #(
  parameter int HF_STAB_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] freq_i,
  input  logic       src_i,
  input  logic       int_now_i,
  input  logic       int_next_i,
  input  logic       lf_rdy_i,
  input  logic       keep_lf_i,
  output logic       hf_en_o,
  output logic       lf_en_o,
  output logic       hf_stab_o,
  output logic       int_stab_o
);
  localparam int CntW = $clog2(HF_STAB_CYCLES + 1);

  logic            lf_sel;
  logic [CntW-1:0] cnt_q;

  assign lf_sel  = (freq_i == 3'b000) && !src_i;
  assign hf_en_o = !lf_sel && int_now_i;
  assign lf_en_o = (lf_sel && int_now_i) || keep_lf_i;

  // int_next_i uses the next active source so the flag drops on the switch edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (lf_sel || !int_next_i)                cnt_q <= '0;
    else if (cnt_q != CntW'(HF_STAB_CYCLES))       cnt_q <= cnt_q + CntW'(1);
  end

  assign hf_stab_o  = hf_en_o && (cnt_q == CntW'(HF_STAB_CYCLES));
  assign int_stab_o = lf_sel ? lf_rdy_i : hf_stab_o;

  assert_hf_settle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hf_stab_o) |-> $past(hf_en_o));
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl import clk_src_pkg::*; #(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 2000,
  parameter int SW_DLY          = 3,
  parameter int HF_STAB_CYCLES  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sec_en_i,
  input  logic       sec_rdy_i,
  input  logic       pll_en_i,
  input  logic [2:0] freq_i,
  input  logic       int_src_i,
  input  logic       lf_rdy_i,
  input  logic       wdt_en_i,
  input  logic       fscm_en_i,
  output logic [1:0] act_src_o,
  output logic       pri_en_o,
  output logic       ost_done_o,
  output logic       sec_run_o,
  output logic       hf_en_o,
  output logic       hf_stab_o,
  output logic       lf_en_o,
  output logic       int_stab_o
);
  src_e tgt, act_q, act_d;
  logic pri_rdy, sec_ok, ost_q, sec_q, int_now, int_next;

  assign tgt      = sel_to_src(sel_i);
  assign sec_ok   = sec_en_i && sec_rdy_i;
  assign pri_en_o = (tgt == SRC_PRI) || (act_q == SRC_PRI);
  assign int_now  = (tgt == SRC_INT) || (act_q == SRC_INT);
  assign int_next = (tgt == SRC_INT) || (act_d == SRC_INT);

  ost_timer #(
    .OST_CYCLES     (OST_CYCLES),
    .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES)
  ) u_ost (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pri_en_o),
    .pll_en_i(pll_en_i),
    .rdy_o   (pri_rdy)
  );

  switch_seq #(.SW_DLY(SW_DLY)) u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt),
    .pri_rdy_i(pri_rdy),
    .sec_ok_i (sec_ok),
    .act_o    (act_q),
    .act_d_o  (act_d)
  );

  int_osc_mon #(.HF_STAB_CYCLES(HF_STAB_CYCLES)) u_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .freq_i    (freq_i),
    .src_i     (int_src_i),
    .int_now_i (int_now),
    .int_next_i(int_next),
    .lf_rdy_i  (lf_rdy_i),
    .keep_lf_i (wdt_en_i || fscm_en_i),
    .hf_en_o   (hf_en_o),
    .lf_en_o   (lf_en_o),
    .hf_stab_o (hf_stab_o),
    .int_stab_o(int_stab_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ost_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      ost_q <= (act_d == SRC_PRI) && pri_rdy;
      sec_q <= (act_d == SRC_SEC);
    end
  end

  assign act_src_o  = act_q;
  assign ost_done_o = ost_q;
  assign sec_run_o  = sec_q;

  assert_sec_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_run_o == (act_src_o == SRC_SEC));

  assert_ost_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_src_o != SRC_PRI |-> !ost_done_o);

  assert_ost_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ost_done_o) |-> act_src_o == SRC_PRI);
endmodule

// File: tb/sim_clk_src_ctrl.sv
module sim_clk_src_ctrl;
  localparam int OST = 1024;
  localparam int PLL = 2000;
  localparam int SW  = 3;
  localparam int HF  = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       sec_en_i = 1'b0, sec_rdy_i = 1'b0, pll_en_i = 1'b0;
  logic [2:0] freq_i = 3'b000;
  logic       int_src_i = 1'b0, lf_rdy_i = 1'b0, wdt_en_i = 1'b0, fscm_en_i = 1'b0;
  logic [1:0] act_src_o;
  logic       pri_en_o, ost_done_o, sec_run_o, hf_en_o, hf_stab_o, lf_en_o, int_stab_o;

  always #2 clk = ~clk;

  clk_src_ctrl #(
    .OST_CYCLES(OST), .PLL_LOCK_CYCLES(PLL), .SW_DLY(SW), .HF_STAB_CYCLES(HF)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .sec_en_i(sec_en_i),
    .sec_rdy_i(sec_rdy_i), .pll_en_i(pll_en_i), .freq_i(freq_i),
    .int_src_i(int_src_i), .lf_rdy_i(lf_rdy_i), .wdt_en_i(wdt_en_i),
    .fscm_en_i(fscm_en_i), .act_src_o(act_src_o), .pri_en_o(pri_en_o),
    .ost_done_o(ost_done_o), .sec_run_o(sec_run_o), .hf_en_o(hf_en_o),
    .hf_stab_o(hf_stab_o), .lf_en_o(lf_en_o), .int_stab_o(int_stab_o)
  );

  typedef enum int {S_ACT, S_PRI_EN, S_OST, S_SEC, S_HF_EN, S_HF_STAB, S_LF_EN, S_INT_STAB} sig_e;
  typedef struct {
    int    due;
    sig_e  sig;
    int    exp;
    string req;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  function automatic int sample(sig_e s);
    case (s)
      S_ACT:      return int'(act_src_o);
      S_PRI_EN:   return int'(pri_en_o);
      S_OST:      return int'(ost_done_o);
      S_SEC:      return int'(sec_run_o);
      S_HF_EN:    return int'(hf_en_o);
      S_HF_STAB:  return int'(hf_stab_o);
      S_LF_EN:    return int'(lf_en_o);
      default:    return int'(int_stab_o);
    endcase
  endfunction

  task automatic expect_at(int due, sig_e s, int v, string req);
    item_t it;
    it.due = due; it.sig = s; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops items as their edge arrives
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      int    got;
      it  = sb_q.pop_front();
      got = sample(it.sig);
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s edge=%0d sig=%s actual=%0d expected=%0d",
                 it.req, cyc, it.sig.name(), got, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    step(3);
    rst_ni = 1'b1;
    // R1 reset state and first start-up
    expect_at(1, S_ACT, 0, "R1");
    expect_at(1, S_PRI_EN, 1, "R1");
    expect_at(1, S_OST, 0, "R1");
    expect_at(1, S_SEC, 0, "R1");
    expect_at(OST, S_OST, 0, "R1");
    expect_at(OST + 1, S_OST, 1, "R1");
    step(OST + 3);

    // R3: secondary requested but not enabled or not ready
    sel_i = 2'b01;
    n = cyc;
    expect_at(n + 8, S_ACT, 0, "R3");
    expect_at(n + 8, S_PRI_EN, 1, "R3");
    step(9);
    sec_en_i = 1'b1;
    n = cyc;
    expect_at(n + 6, S_ACT, 0, "R3");
    step(7);
    // R4/R5: ready arrives, switch after SW ready edges
    sec_rdy_i = 1'b1;
    n = cyc;
    expect_at(n + SW - 1, S_ACT, 0, "R4");
    expect_at(n + SW, S_ACT, 1, "R4");
    expect_at(n + SW, S_SEC, 1, "R5");
    expect_at(n + SW, S_OST, 0, "R5");
    expect_at(n + SW, S_PRI_EN, 0, "R5");
    step(SW + 3);

    // R7/R9: back to primary without PLL
    sel_i = 2'b00;
    n = cyc;
    expect_at(n + 1, S_PRI_EN, 1, "R7");
    expect_at(n + 1, S_ACT, 1, "R7");
    expect_at(n + OST, S_SEC, 1, "R7");
    expect_at(n + OST + SW - 1, S_ACT, 1, "R7");
    expect_at(n + OST + SW, S_ACT, 0, "R7");
    expect_at(n + OST + SW, S_OST, 1, "R9");
    expect_at(n + OST + SW, S_SEC, 0, "R9");
    step(OST + SW + 3);

    // R6/R10: internal run on the low-frequency source
    lf_rdy_i = 1'b1;
    sel_i = 2'b10;
    n = cyc;
    expect_at(n + 1, S_LF_EN, 1, "R10");
    expect_at(n + 1, S_HF_EN, 0, "R10");
    expect_at(n + 1, S_INT_STAB, 1, "R10");
    expect_at(n + SW, S_ACT, 0, "R4");
    expect_at(n + SW + 1, S_ACT, 2, "R4");
    expect_at(n + SW + 1, S_OST, 0, "R6");
    expect_at(n + SW + 1, S_PRI_EN, 0, "R6");
    step(SW + 3);
    lf_rdy_i = 1'b0;
    n = cyc;
    expect_at(n + 1, S_INT_STAB, 0, "R10");
    step(2);
    // R2: lower select bit ignored while upper bit set
    sel_i = 2'b11;
    n = cyc;
    expect_at(n + 1, S_PRI_EN, 0, "R2");
    expect_at(n + 6, S_ACT, 2, "R2");
    step(7);

    // R11: switch to the high-frequency source
    freq_i = 3'b011;
    n = cyc;
    expect_at(n + 1, S_HF_EN, 1, "R10");
    expect_at(n + 1, S_LF_EN, 0, "R10");
    expect_at(n + HF - 1, S_HF_STAB, 0, "R11");
    expect_at(n + HF, S_HF_STAB, 1, "R11");
    expect_at(n + HF, S_INT_STAB, 1, "R11");
    step(HF + 2);
    freq_i = 3'b101;
    n = cyc;
    expect_at(n + 1, S_HF_STAB, 1, "R11");
    step(2);
    freq_i = 3'b000;
    int_src_i = 1'b1;
    n = cyc;
    expect_at(n + 1, S_HF_STAB, 1, "R10");
    expect_at(n + 1, S_INT_STAB, 1, "R10");
    expect_at(n + 1, S_LF_EN, 0, "R10");
    step(2);
    freq_i = 3'b101;
    int_src_i = 1'b0;
    step(1);

    // R8/R9/R12: back to primary through the PLL with watchdog on
    wdt_en_i = 1'b1;
    pll_en_i = 1'b1;
    sel_i = 2'b00;
    n = cyc;
    expect_at(n + 1, S_PRI_EN, 1, "R7");
    expect_at(n + 1, S_LF_EN, 1, "R12");
    expect_at(n + OST + SW, S_ACT, 2, "R8");
    expect_at(n + OST + PLL + SW - 1, S_ACT, 2, "R8");
    expect_at(n + OST + PLL + SW - 1, S_HF_STAB, 1, "R9");
    expect_at(n + OST + PLL + SW, S_ACT, 0, "R8");
    expect_at(n + OST + PLL + SW, S_OST, 1, "R9");
    expect_at(n + OST + PLL + SW, S_HF_STAB, 0, "R9");
    expect_at(n + OST + PLL + SW, S_HF_EN, 0, "R9");
    expect_at(n + OST + PLL + SW, S_LF_EN, 1, "R12");
    step(OST + PLL + SW + 3);
    wdt_en_i = 1'b0;
    n = cyc;
    expect_at(n + 1, S_LF_EN, 0, "R12");
    step(2);
    fscm_en_i = 1'b1;
    n = cyc;
    expect_at(n + 1, S_LF_EN, 1, "R12");
    step(2);

    // R13: retarget while a switch to internal is pending
    sel_i = 2'b10;
    n = cyc;
    step(2);
    sel_i = 2'b01;
    expect_at(n + 4, S_ACT, 0, "R13");
    expect_at(n + 5, S_ACT, 0, "R13");
    expect_at(n + 6, S_ACT, 1, "R13");
    expect_at(n + 6, S_SEC, 1, "R13");
    step(8);

    step(3);
    done = 1'b1;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R1 pending items actual=%0d expected=0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule